// File: doc/BRIEF.md
# I2C Master Bus Condition Sequencer

This block finishes a master-receiver transfer on an open-drain I2C bus. After the byte engine has taken in a byte and answered it with a not-acknowledge, it pulses `byte_done`. The block then holds SCL low and reports status 0x58. Software writes a start request, a stop request or both, and clears the interrupt flag. The block then walks SDA and SCL through the needed phases. It can produce a repeated START, a STOP, or a STOP followed at once by a fresh START.

The block only pulls the lines low; it never drives them high. Each phase lasts a programmable number of half-bit ticks. Any phase in which SCL has been let go does not begin counting until the synchronized SCL input reads high, so a slave holding SCL low stretches that phase. After a STOP, the block pulses `stop_clr` so that the software-visible stop request clears itself. The status byte then reports where the bus ended up.

Top module: `i2c_cond_gen`

## Requirements
- R1: While reset is asserted and right after it, `scl_oe` = 0, `sda_oe` = 0, `stop_clr` = 0 and `status` = 0xF8.
- R2: A `byte_done` pulse, from any state, gives on the next cycle `status` = 0x58 with `scl_oe` = 1 and `sda_oe` = 0.
- R3: While `status` is 0x58, the lines and the status do not change if `irq_flag` = 1 or if neither `req_start` nor `req_stop` is set.
- R4: With `req_start` = 1 and `req_stop` = 0, exactly one START appears on the bus (SDA falls while SCL is high) and no STOP. The block then ends with `status` = 0x10, `scl_oe` = 1 and `sda_oe` = 1.
- R5: With `req_start` = 0 and `req_stop` = 1, exactly one STOP appears (SDA rises while SCL is high). The block ends with both lines released and `status` = 0xF8. `stop_clr` pulses high for exactly one cycle, in a cycle where `status` is already 0xF8 and both enables are 0.
- R6: With both requests set, a STOP and then a START appear, in that order. The block ends with `status` = 0x08 and both enables at 1, and gives one `stop_clr` pulse.
- R7: Each START or STOP edge comes only after at least `PHASE_TICKS` ticks during which SCL was high. A phase with SCL released starts counting only once the synchronized `scl_in` is high. `scl_oe` is raised again only in the cycle after `scl_in` was seen high.
- R8: Apart from the cycle after a `byte_done` and the cycle after the action is launched, `scl_oe` and `sda_oe` change only in the cycle after a `tick`.
- R9: Requests are ignored when `status` is not 0x58 (idle 0xF8, or after 0x10 or 0x08). The lines, the status and `stop_clr` stay put.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_done | input | 1 | Pulse: byte received and not-acknowledge returned |
| irq_flag | input | 1 | Interrupt flag; action proceeds only while 0 |
| req_start | input | 1 | Software start request |
| req_stop | input | 1 | Software stop request |
| tick | input | 1 | Half-bit-period timing pulse |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| stop_clr | output | 1 | One-cycle pulse clearing the stop request |
| status | output | 8 | Status code |

## Verification
The hardest case to reach is a slave stretching the clock in the middle of a condition phase. Here SCL is held low after the block has released it, while ticks keep arriving. A block that counts these ticks too early moves SDA with SCL still low, and the bus then sees no valid condition. To reach this case, the bench's bus model holds SCL low for a random 0 to 24 cycles after each release, while ticks come at random spacing. At every START or STOP edge, it counts the ticks seen with SCL high.

// File: rtl/i2c_cg_pkg.sv
package i2c_cg_pkg;

  localparam logic [7:0] CODE_RX_NACK = 8'h58;
  localparam logic [7:0] CODE_RSTART  = 8'h10;
  localparam logic [7:0] CODE_START   = 8'h08;
  localparam logic [7:0] CODE_IDLE    = 8'hF8;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_HOLD,
    SQ_RS_PREP,
    SQ_RS_HIGH,
    SQ_RS_COND,
    SQ_SP_PREP,
    SQ_SP_HIGH,
    SQ_SP_FREE,
    SQ_ST_COND,
    SQ_OWNED
  } seq_state_e;

  // per-state line drive and timing qualifiers
  typedef struct packed {
    logic scl_low;
    logic sda_low;
    logic timed;
    logic need_scl;
    logic need_sda;
  } drive_t;

endpackage

// File: rtl/cg_line_sync.sv
module cg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_q
);

  logic [STAGES-1:0] pipe;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= 1'b1;
          else        pipe[g] <= line_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= 1'b1;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign line_q = pipe[STAGES-1];

endmodule

// File: rtl/cg_phase_timer.sv
module cg_phase_timer #(
  parameter int PHASE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  input  logic gate,
  output logic done
);

  localparam int CW = $clog2(PHASE_TICKS) + 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          step;

  assign step = tick && gate;
  assign done = step && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cg_status_reg.sv
module cg_status_reg import i2c_cg_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] code,
  output logic [7:0] status
);

  logic [7:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (load) stat_d = code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= CODE_IDLE;
    else        stat_q <= stat_d;
  end

  assign status = stat_q;

endmodule

// File: rtl/cg_sequencer.sv
module cg_sequencer import i2c_cg_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_done,
  input  logic       irq_flag,
  input  logic       req_start,
  input  logic       req_stop,
  input  logic       scl_hi,
  input  logic       sda_hi,
  input  logic       phase_done,
  output seq_state_e state,
  output logic       phase_clr,
  output logic       phase_gate,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       stop_clr,
  output logic       code_vld,
  output logic [7:0] code
);

  seq_state_e state_q, state_d;
  logic       combo_q, combo_d;
  logic       clr_q, clr_d;
  drive_t     drv;

  // next-state
  always_comb begin
    state_d  = state_q;
    combo_d  = combo_q;
    clr_d    = 1'b0;
    code_vld = 1'b0;
    code     = CODE_IDLE;
    if (byte_done) begin
      state_d  = SQ_HOLD;
      combo_d  = 1'b0;
      code_vld = 1'b1;
      code     = CODE_RX_NACK;
    end else begin
      case (state_q)
        SQ_HOLD: begin
          if (!irq_flag && (req_start || req_stop)) begin
            combo_d = req_start && req_stop;
            state_d = req_stop ? SQ_SP_PREP : SQ_RS_PREP;
          end
        end
        SQ_RS_PREP: if (phase_done) state_d = SQ_RS_HIGH;
        SQ_RS_HIGH: if (phase_done) state_d = SQ_RS_COND;
        SQ_RS_COND: begin
          if (phase_done) begin
            state_d  = SQ_OWNED;
            code_vld = 1'b1;
            code     = CODE_RSTART;
          end
        end
        SQ_SP_PREP: if (phase_done) state_d = SQ_SP_HIGH;
        SQ_SP_HIGH: begin
          if (phase_done) begin
            state_d  = SQ_SP_FREE;
            clr_d    = 1'b1;
            code_vld = 1'b1;
            code     = CODE_IDLE;
          end
        end
        SQ_SP_FREE: if (phase_done) state_d = combo_q ? SQ_ST_COND : SQ_IDLE;
        SQ_ST_COND: begin
          if (phase_done) begin
            state_d  = SQ_OWNED;
            code_vld = 1'b1;
            code     = CODE_START;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  // line drive decode from the registered state
  always_comb begin
    drv = '0;
    case (state_q)
      SQ_HOLD:    drv = '{scl_low: 1'b1, sda_low: 1'b0, timed: 1'b0, need_scl: 1'b0, need_sda: 1'b0};
      SQ_RS_PREP: drv = '{scl_low: 1'b1, sda_low: 1'b0, timed: 1'b1, need_scl: 1'b0, need_sda: 1'b0};
      SQ_RS_HIGH: drv = '{scl_low: 1'b0, sda_low: 1'b0, timed: 1'b1, need_scl: 1'b1, need_sda: 1'b0};
      SQ_RS_COND: drv = '{scl_low: 1'b0, sda_low: 1'b1, timed: 1'b1, need_scl: 1'b1, need_sda: 1'b0};
      SQ_SP_PREP: drv = '{scl_low: 1'b1, sda_low: 1'b1, timed: 1'b1, need_scl: 1'b0, need_sda: 1'b0};
      SQ_SP_HIGH: drv = '{scl_low: 1'b0, sda_low: 1'b1, timed: 1'b1, need_scl: 1'b1, need_sda: 1'b0};
      SQ_SP_FREE: drv = '{scl_low: 1'b0, sda_low: 1'b0, timed: 1'b1, need_scl: 1'b1, need_sda: 1'b1};
      SQ_ST_COND: drv = '{scl_low: 1'b0, sda_low: 1'b1, timed: 1'b1, need_scl: 1'b1, need_sda: 1'b0};
      SQ_OWNED:   drv = '{scl_low: 1'b1, sda_low: 1'b1, timed: 1'b0, need_scl: 1'b0, need_sda: 1'b0};
      default:    drv = '0;
    endcase
  end

  assign phase_gate = drv.timed && (!drv.need_scl || scl_hi) && (!drv.need_sda || sda_hi);
  assign phase_clr  = (state_d != state_q);
  assign scl_oe     = drv.scl_low;
  assign sda_oe     = drv.sda_low;
  assign stop_clr   = clr_q;
  assign state      = state_q;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      combo_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      combo_q <= combo_d;
      clr_q   <= clr_d;
    end
  end

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen import i2c_cg_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int PHASE_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_done,
  input  logic       irq_flag,
  input  logic       req_start,
  input  logic       req_stop,
  input  logic       tick,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       stop_clr,
  output logic [7:0] status
);

  logic       scl_hi, sda_hi;
  logic       phase_clr, phase_gate, phase_done;
  logic       code_vld;
  logic [7:0] code;
  seq_state_e seq_state;
  logic       in_hold;

  cg_line_sync #(.STAGES(SYNC_STAGES)) i_sync_scl (
    .clk(clk), .rst_n(rst_n), .line_in(scl_in), .line_q(scl_hi)
  );

  cg_line_sync #(.STAGES(SYNC_STAGES)) i_sync_sda (
    .clk(clk), .rst_n(rst_n), .line_in(sda_in), .line_q(sda_hi)
  );

  cg_phase_timer #(.PHASE_TICKS(PHASE_TICKS)) i_timer (
    .clk(clk), .rst_n(rst_n), .clear(phase_clr), .tick(tick),
    .gate(phase_gate), .done(phase_done)
  );

  cg_sequencer i_seq (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .irq_flag(irq_flag),
    .req_start(req_start), .req_stop(req_stop), .scl_hi(scl_hi), .sda_hi(sda_hi),
    .phase_done(phase_done), .state(seq_state), .phase_clr(phase_clr),
    .phase_gate(phase_gate), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .stop_clr(stop_clr), .code_vld(code_vld), .code(code)
  );

  cg_status_reg i_status (
    .clk(clk), .rst_n(rst_n), .load(code_vld), .code(code), .status(status)
  );

  assign in_hold = (seq_state == SQ_HOLD);

endmodule

// File: rtl/cg_checker.sv
module cg_checker import i2c_cg_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_done,
  input logic       irq_flag,
  input logic       tick,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       stop_clr,
  input logic [7:0] status,
  input logic       scl_hi,
  input logic       in_hold
);

  assert_byte_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (status == CODE_RX_NACK) && scl_oe && !sda_oe);

  assert_hold_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && irq_flag) |=> ($stable(scl_oe) && $stable(sda_oe)));

  assert_rstart_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(status) && status == CODE_RSTART) |-> (scl_oe && sda_oe));

  assert_stop_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_clr && !$past(byte_done)) |-> (status == CODE_IDLE && !scl_oe && !sda_oe));

  assert_stop_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_clr |=> !stop_clr);

  assert_start_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(status) && status == CODE_START) |-> (scl_oe && sda_oe));

  assert_scl_pull_after_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_oe) && !$past(byte_done)) |-> $past(scl_hi));

  assert_edges_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($changed(scl_oe) || $changed(sda_oe)) && !$past(byte_done) && !$past(in_hold))
      |-> $past(tick));

  assert_ignored_requests_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_hold && !byte_done && (status == CODE_IDLE || status == CODE_RSTART || status == CODE_START)
      && !scl_oe && !sda_oe && !stop_clr && !$changed(status))
      |=> (status != CODE_RX_NACK));

  logic unused_flag;
  assign unused_flag = irq_flag;

endmodule

bind i2c_cond_gen cg_checker i_cg_checker (
  .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .irq_flag(irq_flag),
  .tick(tick), .scl_oe(scl_oe), .sda_oe(sda_oe), .stop_clr(stop_clr),
  .status(status), .scl_hi(scl_hi), .in_hold(in_hold)
);

// File: tb/test_i2c_cond_gen.sv
module test_i2c_cond_gen;

  localparam int CLK_PERIOD  = 10;
  localparam int PHASE_TICKS = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_done, irq_flag, req_start, req_stop, tick;
  logic       scl_oe, sda_oe, stop_clr;
  logic [7:0] status;
  int         stretch;
  logic       scl_bus, sda_bus;

  int checks = 0;
  int fails  = 0;
  logic [7:0] ev;
  int n_ev, n_clr, n_r8;

  assign scl_bus = !scl_oe && (stretch == 0);
  assign sda_bus = !sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cond_gen #(.SYNC_STAGES(2), .PHASE_TICKS(PHASE_TICKS)) i_i2c_cond_gen (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .irq_flag(irq_flag),
    .req_start(req_start), .req_stop(req_stop), .tick(tick),
    .scl_in(scl_bus), .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .stop_clr(stop_clr), .status(status)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_events(input bit s, input bit p);
    // START code 1, STOP code 2, newest in low bits
    if (p) return s ? 8'h09 : 8'h02;
    return 8'h01;
  endfunction

  function automatic logic [7:0] exp_status(input bit s, input bit p);
    if (p) return s ? 8'h08 : 8'hF8;
    return 8'h10;
  endfunction

  // bus model and monitor
  initial begin
    logic prev_scl, prev_sda, prev_scl_oe, prev_sda_oe, prev_flag, cur_scl, cur_sda;
    int hi_ticks;
    tick = 1'b0; stretch = 0; ev = '0; n_ev = 0; n_clr = 0; n_r8 = 0; hi_ticks = 0;
    wait (rst_n === 1'b1);
    @(negedge clk);
    prev_scl = scl_bus; prev_sda = sda_bus;
    prev_scl_oe = scl_oe; prev_sda_oe = sda_oe; prev_flag = irq_flag;
    forever begin
      @(negedge clk);
      cur_scl = scl_bus;
      cur_sda = sda_bus;
      if (cur_scl) begin
        if (tick) hi_ticks++;
      end else begin
        hi_ticks = 0;
      end
      if (prev_scl && cur_scl && (prev_sda != cur_sda)) begin
        ev = {ev[5:0], (cur_sda ? 2'd2 : 2'd1)};
        n_ev++;
        check(hi_ticks >= PHASE_TICKS, "R7 high-phase ticks", hi_ticks, PHASE_TICKS);
      end
      if (((scl_oe != prev_scl_oe) || (sda_oe != prev_sda_oe)) && !byte_done
          && !(prev_flag && !irq_flag)) begin
        n_r8++;
        check(tick == 1'b1, "R8 edge without tick", int'(tick), 1);
      end
      if (stop_clr) begin
        n_clr++;
        req_stop = 1'b0;
      end
      if (prev_scl_oe && !scl_oe) stretch = $urandom_range(0, 24);
      else if (stretch > 0)       stretch--;
      prev_scl = cur_scl; prev_sda = cur_sda;
      prev_scl_oe = scl_oe; prev_sda_oe = sda_oe; prev_flag = irq_flag;
      tick = ($urandom_range(0, 2) == 0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic load_byte();
    step(1);
    byte_done = 1'b1;
    irq_flag  = 1'b1;
    step(1);
    byte_done = 1'b0;
    check(status == 8'h58, "R2 status", status, 8'h58);
    check(scl_oe && !sda_oe, "R2 lines", {scl_oe, sda_oe}, 2'b10);
  endtask

  task automatic run_action(input bit s, input bit p);
    string tag;
    tag = p ? (s ? "R6" : "R5") : "R4";
    req_start = s;
    req_stop  = p;
    ev = '0; n_ev = 0; n_clr = 0;
    step($urandom_range(3, 20));
    check(status == 8'h58 && scl_oe && !sda_oe && n_ev == 0, "R3 held by flag",
          {status, scl_oe, sda_oe}, {8'h58, 2'b10});
    irq_flag = 1'b0;
    for (int i = 0; i < 3000 && status != exp_status(s, p); i++) step(1);
    step(80);
    check(ev == exp_events(s, p), {tag, " event order"}, ev, exp_events(s, p));
    check(n_ev == (p && s ? 2 : 1), {tag, " event count"}, n_ev, (p && s ? 2 : 1));
    check(status == exp_status(s, p), {tag, " status"}, status, exp_status(s, p));
    check(scl_oe == s && sda_oe == s, {tag, " lines"}, {scl_oe, sda_oe}, {s, s});
    check(n_clr == int'(p), {tag, " stop_clr pulses"}, n_clr, int'(p));
    if (p) check(req_stop == 1'b0, {tag, " stop request cleared"}, req_stop, 0);
    req_start = 1'b0;
    req_stop  = 1'b0;
  endtask

  task automatic probe_ignored();
    logic [7:0] st0;
    logic       s0, d0;
    st0 = status; s0 = scl_oe; d0 = sda_oe;
    ev = '0; n_ev = 0; n_clr = 0;
    req_start = 1'b1;
    req_stop  = $urandom_range(0, 1);
    step(40);
    check(status == st0 && scl_oe == s0 && sda_oe == d0 && n_ev == 0 && n_clr == 0,
          "R9 request ignored", {status, scl_oe, sda_oe}, {st0, s0, d0});
    req_start = 1'b0;
    req_stop  = 1'b0;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20250611);
    rst_n = 1'b0; byte_done = 1'b0; irq_flag = 1'b0; req_start = 1'b0; req_stop = 1'b0;
    step(3);
    check(status == 8'hF8 && !scl_oe && !sda_oe && !stop_clr, "R1 in reset",
          {status, scl_oe, sda_oe, stop_clr}, {8'hF8, 3'b000});
    rst_n = 1'b1;
    step(2);
    check(status == 8'hF8 && !scl_oe && !sda_oe && !stop_clr, "R1 after reset",
          {status, scl_oe, sda_oe, stop_clr}, {8'hF8, 3'b000});

    // idle: requests ignored
    probe_ignored();

    // no request with flag cleared: nothing moves (R3)
    load_byte();
    irq_flag = 1'b0;
    ev = '0; n_ev = 0;
    step(40);
    check(status == 8'h58 && scl_oe && !sda_oe && n_ev == 0, "R3 no request",
          {status, scl_oe, sda_oe}, {8'h58, 2'b10});
    irq_flag = 1'b1;
    step(1);

    // directed: each action once
    run_action(1'b1, 1'b0);
    probe_ignored();
    load_byte();
    run_action(1'b0, 1'b1);
    probe_ignored();
    load_byte();
    run_action(1'b1, 1'b1);
    probe_ignored();

    // random mix
    for (int t = 0; t < 40; t++) begin
      int k;
      load_byte();
      k = $urandom_range(0, 2);
      run_action(k != 1, k != 0);
      if ($urandom_range(0, 3) == 0) probe_ignored();
    end

    check(n_r8 > 0, "R8 edges observed", n_r8, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule